// File: doc/BRIEF.md
# Bit Field and Single-Bit Manipulation Unit

This block is a one-stage datapath for 16-bit words that handles the bit-field and single-bit work of a small processor core. In one clock it can build a field from a source value (make), merge a source field into an existing destination word (insert), pull a field out of a source word with zero or sign extension (extract), or set, clear, toggle or test a single bit of the source.

The field is described by a 4-bit width code holding the width minus one, so every width from 1 to 16 bits can be given, and a 4-bit position giving the field's lowest bit. The single-bit operations reuse the position input as the bit index. A caller presents one operation per cycle with `in_valid`; the result, and for the test operation a flag, appear registered on the next clock together with `out_valid`.

Top module: `bfu_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the outputs `out_valid`, `out_result` and `out_flag` all become zero.
- R2: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise; when `in_valid` is low, `out_result` and `out_flag` keep their previous values.
- R3: Make (`in_op` = 0): with width W = `in_width_m1` + 1 and position P = `in_offset`, result bit P+i equals source bit i for i from 0 to W-1, and every other result bit is zero.
- R4: Insert (`in_op` = 1): result bits P to P+W-1 take source bits 0 to W-1, and all other result bits equal the corresponding bits of `in_dst`.
- R5: Unsigned extract (`in_op` = 3): result bits 0 to W-1 equal source bits P to P+W-1, and result bits W and above are zero.
- R6: Signed extract (`in_op` = 2): result bits 0 to W-1 equal source bits P to P+W-1, and result bits W and above copy result bit W-1.
- R7: When P+W exceeds 16, field bits that would land above bit 15 are discarded by make and insert, and extract reads zero for source positions above bit 15 (including the sign bit).
- R8: Set (`in_op` = 4), clear (`in_op` = 5) and toggle (`in_op` = 6) force, clear or invert source bit `in_offset` in the result; all other result bits equal the source.
- R9: Test (`in_op` = 7) returns the source unchanged as the result and drives `out_flag` to the value of source bit `in_offset`; every other operation drives `out_flag` low.
- R10: Both extreme widths work: a width code of 15 with position 0 moves the whole word, and a width code of 0 handles a one-bit field at any position, including bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code (0 make, 1 insert, 2 signed extract, 3 unsigned extract, 4 set, 5 clear, 6 toggle, 7 test) |
| in_src | input | 16 | Source word |
| in_dst | input | 16 | Destination word, used by insert only |
| in_width_m1 | input | 4 | Field width minus one |
| in_offset | input | 4 | Field position, or bit index for single-bit operations |
| out_valid | output | 1 | Result valid strobe, one cycle after `in_valid` |
| out_result | output | 16 | Registered result word |
| out_flag | output | 1 | Registered test flag |

## Verification
The bench aims at fields that run past bit 15, where a design that wraps the shift would leak high source bits into low result bits and a design that reads the sign from the wrong place would fill an extracted value with ones. It drives the one-bit and sixteen-bit widths, since an off-by-one in the width code shows up as a missing top bit or a mask that is empty or all ones. Bit operations at index 0 and 15 and test on both a set and a clear bit catch a flag that leaks into non-test operations or a test that alters the result; idle gaps catch outputs that drift or a valid strobe that lingers.

// File: rtl/bfu_pkg.sv
// bfu_pkg: shared widths and the operation encoding of the bit field unit.
// Assumes a word width that is a power of two so the index fits exactly.
package bfu_pkg;

    parameter int DATA_W = 16;
    parameter int IDX_W  = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_MAKE   = 3'd0,
        OP_INSERT = 3'd1,
        OP_EXT_S  = 3'd2,
        OP_EXT_U  = 3'd3,
        OP_BSET   = 3'd4,
        OP_BCLR   = 3'd5,
        OP_BTGL   = 3'd6,
        OP_BTST   = 3'd7
    } bfu_op_e;

endpackage

// File: rtl/bfu_mask_gen.sv
// bfu_mask_gen: builds the field masks from a width code and a position.
// low_mask has the lowest (width_m1+1) bits set; field_mask is low_mask
// moved up by the position, with bits beyond the word simply lost.
// Assumes width_m1 and offset are in range of an IW-bit index.
module bfu_mask_gen #(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input  logic [IW-1:0] width_m1,
    input  logic [IW-1:0] offset,
    output logic [DW-1:0] low_mask,
    output logic [DW-1:0] field_mask
);

    // One comparator per bit: bit g belongs to the field when g <= width_m1.
    for (genvar g = 0; g < DW; g++) begin : g_low
        localparam logic [IW-1:0] BIT_IDX = IW'(g);
        assign low_mask[g] = (width_m1 >= BIT_IDX);
    end

    // Positioned mask used by insert to clear the destination window.
    always_comb begin
        field_mask = low_mask << offset;
    end

endmodule

// File: rtl/bfu_field_path.sv
// bfu_field_path: combinational make, insert and extract results.
// All four results are produced in parallel; the top selects one.
// Assumes the masks come from bfu_mask_gen for the same width and position.
module bfu_field_path #(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] dst,
    input  logic [IW-1:0] width_m1,
    input  logic [IW-1:0] offset,
    input  logic [DW-1:0] low_mask,
    input  logic [DW-1:0] field_mask,
    output logic [DW-1:0] make_res,
    output logic [DW-1:0] insert_res,
    output logic [DW-1:0] ext_u_res,
    output logic [DW-1:0] ext_s_res
);

    logic [DW-1:0] placed;
    logic [DW-1:0] aligned;
    logic [DW-1:0] picked;
    logic          sign_bit;

    // Place the low field of the source at the position; high overflow drops.
    always_comb begin
        placed   = (src & low_mask) << offset;
        make_res = placed;
    end

    // Merge the placed field into the destination outside the window.
    always_comb begin
        insert_res = (dst & ~field_mask) | placed;
    end

    // Logical right shift brings zeros in for positions above the word.
    always_comb begin
        aligned   = src >> offset;
        picked    = aligned & low_mask;
        ext_u_res = picked;
    end

    // Sign comes from the field's top bit after alignment (zero if overflowed).
    always_comb begin
        sign_bit  = aligned[width_m1];
        ext_s_res = picked | ({DW{sign_bit}} & ~low_mask);
    end

endmodule

// File: rtl/bfu_bit_path.sv
// bfu_bit_path: combinational single-bit set, clear, toggle and test.
// The index selects one bit of the source; the test flag is that bit.
// Assumes index < DW, which an IW-bit index guarantees for powers of two.
module bfu_bit_path #(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input  logic [DW-1:0] src,
    input  logic [IW-1:0] index,
    output logic [DW-1:0] set_res,
    output logic [DW-1:0] clr_res,
    output logic [DW-1:0] tgl_res,
    output logic          bit_val
);

    logic [DW-1:0] sel;

    // One-hot selector for the addressed bit.
    always_comb begin
        sel = {{(DW-1){1'b0}}, 1'b1} << index;
    end

    // The three modifying variants and the tested bit, side by side.
    always_comb begin
        set_res = src | sel;
        clr_res = src & ~sel;
        tgl_res = src ^ sel;
        bit_val = |(src & sel);
    end

endmodule

// File: rtl/bfu_unit.sv
// bfu_unit: top of the bit field and single-bit manipulation unit.
// One operation per cycle enters with in_valid; the selected result and
// the test flag are registered and appear with out_valid one clock later.
// Assumes a synchronous active-low reset and a free-running clock.
module bfu_unit #(
    parameter int DW = bfu_pkg::DATA_W,
    parameter int IW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [DW-1:0] in_src,
    input  logic [DW-1:0] in_dst,
    input  logic [IW-1:0] in_width_m1,
    input  logic [IW-1:0] in_offset,
    output logic          out_valid,
    output logic [DW-1:0] out_result,
    output logic          out_flag
);

    import bfu_pkg::*;

    bfu_op_e       op;
    logic [DW-1:0] low_mask;
    logic [DW-1:0] field_mask;
    logic [DW-1:0] make_res;
    logic [DW-1:0] insert_res;
    logic [DW-1:0] ext_u_res;
    logic [DW-1:0] ext_s_res;
    logic [DW-1:0] set_res;
    logic [DW-1:0] clr_res;
    logic [DW-1:0] tgl_res;
    logic          bit_val;
    logic [DW-1:0] nxt_result;
    logic          nxt_flag;

    // Interpret the raw code as the operation type.
    always_comb begin
        op = bfu_op_e'(in_op);
    end

    bfu_mask_gen #(.DW(DW), .IW(IW)) i_mask (
        .width_m1   (in_width_m1),
        .offset     (in_offset),
        .low_mask   (low_mask),
        .field_mask (field_mask)
    );

    bfu_field_path #(.DW(DW), .IW(IW)) i_field (
        .src        (in_src),
        .dst        (in_dst),
        .width_m1   (in_width_m1),
        .offset     (in_offset),
        .low_mask   (low_mask),
        .field_mask (field_mask),
        .make_res   (make_res),
        .insert_res (insert_res),
        .ext_u_res  (ext_u_res),
        .ext_s_res  (ext_s_res)
    );

    bfu_bit_path #(.DW(DW), .IW(IW)) i_bit (
        .src     (in_src),
        .index   (in_offset),
        .set_res (set_res),
        .clr_res (clr_res),
        .tgl_res (tgl_res),
        .bit_val (bit_val)
    );

    // Pick the result for the requested operation; flag only for test.
    always_comb begin
        nxt_flag = 1'b0;
        unique case (op)
            OP_MAKE:   nxt_result = make_res;
            OP_INSERT: nxt_result = insert_res;
            OP_EXT_S:  nxt_result = ext_s_res;
            OP_EXT_U:  nxt_result = ext_u_res;
            OP_BSET:   nxt_result = set_res;
            OP_BCLR:   nxt_result = clr_res;
            OP_BTGL:   nxt_result = tgl_res;
            OP_BTST: begin
                nxt_result = in_src;
                nxt_flag   = bit_val;
            end
            default:   nxt_result = in_src;
        endcase
    end

    // Valid strobe follows the input by exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Output data loads on a valid input and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_flag   <= 1'b0;
        end else if (in_valid) begin
            out_result <= nxt_result;
            out_flag   <= nxt_flag;
        end
    end

endmodule

// File: rtl/bfu_unit_chk.sv
// bfu_unit_chk: protocol and single-bit properties of bfu_unit, bound in.
// Relates the input port of one cycle to the output ports of the next.
module bfu_unit_chk #(
    parameter int DW = 16,
    parameter int IW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_op,
    input logic [DW-1:0] in_src,
    input logic [IW-1:0] in_offset,
    input logic          out_valid,
    input logic [DW-1:0] out_result,
    input logic          out_flag
);

    // R2: an accepted operation yields a strobe next cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no input, no strobe.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: outputs hold through idle cycles.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_flag)));

    // R9: test returns the source and reports the addressed bit.
    a_r9_test_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd7) |=>
            (out_result == $past(in_src)) && (out_flag == $past(in_src[in_offset])));

    // R9: the flag stays low for every other operation.
    a_r9_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 3'd7) |=> !out_flag);

    // R8: set leaves the addressed bit at one.
    a_r8_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd4) |=> out_result[$past(in_offset)]);

    // R8: clear leaves the addressed bit at zero.
    a_r8_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd5) |=> !out_result[$past(in_offset)]);

endmodule

bind bfu_unit bfu_unit_chk #(.DW(DW), .IW(IW)) i_bfu_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_src     (in_src),
    .in_offset  (in_offset),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flag   (out_flag)
);

// File: tb/test_bfu_unit.sv
`timescale 1ns/1ps
// test_bfu_unit: scoreboard bench. The driver pushes model results into
// queues; the monitor pops one per output strobe and compares.
module test_bfu_unit;

    localparam int DW = 16;
    localparam int WATCHDOG = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [DW-1:0] in_src = '0;
    logic [DW-1:0] in_dst = '0;
    logic [3:0]    in_width_m1 = '0;
    logic [3:0]    in_offset = '0;
    logic          out_valid;
    logic [DW-1:0] out_result;
    logic          out_flag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [DW-1:0] q_res[$];
    logic          q_flag[$];
    string         q_tag[$];

    bfu_unit i_bfu_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .in_src      (in_src),
        .in_dst      (in_dst),
        .in_width_m1 (in_width_m1),
        .in_offset   (in_offset),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_flag    (out_flag)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-by-bit model written from the requirements.
    function automatic logic [DW:0] model(input logic [2:0] op, input logic [DW-1:0] s,
                                          input logic [DW-1:0] d, input int w, input int p);
        logic [DW-1:0] r;
        logic f;
        r = s;
        f = 1'b0;
        case (op)
            3'd0, 3'd1: begin
                r = (op == 3'd0) ? '0 : d;
                for (int i = 0; i < w; i++)
                    if (p + i < DW) r[p+i] = s[i];
            end
            3'd2, 3'd3: begin
                r = '0;
                for (int i = 0; i < w; i++)
                    r[i] = (p + i < DW) ? s[p+i] : 1'b0;
                if (op == 3'd2)
                    for (int i = w; i < DW; i++) r[i] = r[w-1];
            end
            3'd4: r[p] = 1'b1;
            3'd5: r[p] = 1'b0;
            3'd6: r[p] = ~s[p];
            default: f = s[p];
        endcase
        return {f, r};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3 make";
            3'd1: return "R4 insert";
            3'd2: return "R6 signed extract";
            3'd3: return "R5 unsigned extract";
            3'd7: return "R9 test";
            default: return "R8 bit op";
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic [DW-1:0] s, input logic [DW-1:0] d,
                         input int w, input int p, input string tag);
        logic [DW:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        in_op = op;
        in_src = s;
        in_dst = d;
        in_width_m1 = 4'(w - 1);
        in_offset = 4'(p);
        e = model(op, s, d, w, p);
        q_res.push_back(e[DW-1:0]);
        q_flag.push_back(e[DW]);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_src = ~in_src;
        end
    endtask

    // Monitor: one expected item per output strobe.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_res.size() == 0) begin
                check("R2 unexpected strobe", 32'd1, 32'd0);
            end else begin
                string t;
                logic [DW-1:0] er;
                logic ef;
                er = q_res.pop_front();
                ef = q_flag.pop_front();
                t = q_tag.pop_front();
                check(t, {15'd0, out_flag, out_result}, {15'd0, ef, er});
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(WATCHDOG * 5);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] held;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset result", {16'd0, out_result}, 32'd0);
        check("R1 reset flag", {31'd0, out_flag}, 32'd0);
        rst_n = 1'b1;

        // R2: latency and hold across an idle gap
        drive(3'd0, 16'h00A5, 16'h0, 8, 4, "R3 make mid");
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 strobe after input", {31'd0, out_valid}, 32'd1);
        held = out_result;
        @(negedge clk);
        check("R2 strobe drops", {31'd0, out_valid}, 32'd0);
        idle(3);
        check("R2 result held", {16'd0, out_result}, {16'd0, held});

        // Field corners
        drive(3'd0, 16'hBEEF, 16'h0, 16, 0, "R10 make full width");
        drive(3'd0, 16'h0001, 16'h0, 1, 15, "R10 make one bit top");
        drive(3'd0, 16'h00FF, 16'h0, 8, 12, "R7 make overflow");
        drive(3'd1, 16'h0009, 16'hFFFF, 4, 4, "R4 insert");
        drive(3'd1, 16'h003F, 16'h1234, 6, 13, "R7 insert overflow");
        drive(3'd1, 16'h5A5A, 16'h0F0F, 16, 0, "R10 insert full width");
        drive(3'd3, 16'h00F8, 16'h0, 5, 3, "R5 unsigned extract");
        drive(3'd2, 16'h00F8, 16'h0, 5, 3, "R6 signed extract neg");
        drive(3'd2, 16'h0078, 16'h0, 5, 3, "R6 signed extract pos");
        drive(3'd2, 16'hF000, 16'h0, 8, 12, "R7 signed extract overflow");
        drive(3'd3, 16'hF000, 16'h0, 8, 12, "R7 unsigned extract overflow");
        drive(3'd2, 16'h8000, 16'h0, 1, 15, "R10 signed extract one bit");
        drive(3'd2, 16'h8001, 16'h0, 16, 0, "R10 signed extract full");
        // Single-bit corners
        drive(3'd4, 16'h0000, 16'h0, 1, 15, "R8 set bit 15");
        drive(3'd5, 16'hFFFF, 16'h0, 1, 0, "R8 clear bit 0");
        drive(3'd6, 16'h8001, 16'h0, 1, 15, "R8 toggle bit 15");
        drive(3'd7, 16'h0400, 16'h0, 1, 10, "R9 test one");
        drive(3'd7, 16'hFBFF, 16'h0, 1, 10, "R9 test zero");
        drive(3'd4, 16'h0400, 16'h0, 1, 10, "R9 flag low after set");
        idle(2);

        // Mixed stream with occasional gaps
        for (int n = 0; n < 400; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            drive(op, 16'($urandom), 16'($urandom), $urandom_range(1, 16),
                  $urandom_range(0, 15), tag_of(op));
            if ((n % 17) == 0) idle(1);
        end
        idle(4);
        check("R2 all results delivered", q_res.size(), 32'd0);
        finish_run();
    end

endmodule